// File: doc/BRIEF.md
# Programmable Divide-by-N Pulse Generator

This block produces a one-cycle pulse once every N enabled cycles of its clock. The result is used as a clock enable for slower logic in the same clock domain, so no derived clock is ever created. The divisor N arrives as an unsigned integer on a parallel input.

The core is a down-counter with a preset. On each enabled cycle a per-bit multiplexer picks the next count. When the count is not zero, the multiplexer takes the decremented value. When the count is zero, it takes the freshly computed reload value. The reload and the output pulse happen on the same edge, so consecutive periods follow each other with no idle cycle.

An enable input freezes the counter while it is low. The divisor is read only at reload edges. A divisor of zero is treated as one.

Top module: `pulse_div_gen`

## Requirements
- R1: Reset is synchronous and active high. An edge with `rst_i` high leaves `tick_o` low. The first edge with `en_i` high after reset loads the divisor and produces no pulse.
- R2: `tick_o` is high for one cycle at a time. It is high only after an edge at which `en_i` was high.
- R3: With `en_i` held high and a divisor N of 1 or more, the first pulse follows the (N+1)-th enabled edge after reset. After that, pulses are exactly N enabled edges apart.
- R4: `div_i` is sampled only on reload edges, meaning the pulse edge and the first load after reset. A change in the middle of a period takes effect in the next period.
- R5: With a divisor of 1, `tick_o` is high after every enabled edge once the post-reset load is done.
- R6: A divisor of 0 gives exactly the same pulse pattern as a divisor of 1.
- R7: While `en_i` is low the count holds its value, including a count that has already reached zero. The pending pulse is then issued on the next enabled edge.
- R8: The pulse and the reload of the next period occur on the same edge. There is no extra cycle between periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable; low freezes the count |
| div_i | input | CNT_W | Divisor N, unsigned; 0 treated as 1 |
| tick_o | output | 1 | Registered one-cycle pulse, one per N enabled cycles |

## Verification
Two events can fall in the same cycle: the zero-detect pulse and the reload of a new divisor. This happens on every period boundary, so the bench changes `div_i` in the middle of a period. It then checks that the current period keeps its old length and that the next period has the new length, with no idle gap between them.

A second collision comes from dropping `en_i` in exactly the cycle where the count sits at zero. The bench checks that the pulse is held back rather than lost or repeated, and that it appears on the next enabled edge.

// File: rtl/pdg_pkg.sv
package pdg_pkg;
   localparam int unsigned PDG_DEF_CNT_W = 8;
   localparam int unsigned PDG_ZD_CHUNK  = 4;

   typedef enum logic {
      PH_PRIME = 1'b0,
      PH_RUN   = 1'b1
   } pdg_phase_e;
endpackage

// File: rtl/pdg_reload_calc.sv
module pdg_reload_calc #(
   parameter int unsigned CNT_W = pdg_pkg::PDG_DEF_CNT_W
) (
   input  logic [CNT_W-1:0] div_i,
   output logic [CNT_W-1:0] reload_o
);
   // A period of N cycles is counted as N-1 down to 0; zero behaves as one.
   logic div_is_zero;
   assign div_is_zero = (div_i == '0);

   always_comb begin
      if (div_is_zero) reload_o = '0;
      else             reload_o = div_i - CNT_W'(1);
   end
endmodule

// File: rtl/pdg_zero_det.sv
module pdg_zero_det #(
   parameter int unsigned CNT_W = pdg_pkg::PDG_DEF_CNT_W,
   parameter int unsigned CHUNK = pdg_pkg::PDG_ZD_CHUNK
) (
   input  logic [CNT_W-1:0] cnt_i,
   output logic             zero_o
);
   localparam int unsigned N_CH  = (CNT_W + CHUNK - 1) / CHUNK;
   localparam int unsigned PAD_W = N_CH * CHUNK;

   if (CHUNK < 1) begin : g_bad_chunk
      $error("pdg_zero_det: CHUNK must be at least 1");
   end

   if (CNT_W <= CHUNK) begin : g_flat
      assign zero_o = ~|cnt_i;
   end else begin : g_tree
      logic [PAD_W-1:0] padded;
      logic [N_CH-1:0]  nz;
      assign padded = PAD_W'(cnt_i);
      for (genvar c = 0; c < N_CH; c++) begin : g_ch
         assign nz[c] = |padded[c*CHUNK +: CHUNK];
      end
      assign zero_o = ~|nz;
   end
endmodule

// File: rtl/pdg_next_mux.sv
module pdg_next_mux #(
   parameter int unsigned CNT_W = pdg_pkg::PDG_DEF_CNT_W
) (
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] load_i,
   input  logic             sel_load_i,
   output logic [CNT_W-1:0] next_o
);
   logic [CNT_W-1:0] dec;
   assign dec = cnt_i - CNT_W'(1);

   for (genvar b = 0; b < CNT_W; b++) begin : g_bit
      assign next_o[b] = sel_load_i ? load_i[b] : dec[b];
   end
endmodule

// File: rtl/pulse_div_gen.sv
module pulse_div_gen #(
   parameter int unsigned CNT_W    = pdg_pkg::PDG_DEF_CNT_W,
   parameter int unsigned ZD_CHUNK = pdg_pkg::PDG_ZD_CHUNK
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             en_i,
   input  logic [CNT_W-1:0] div_i,
   output logic             tick_o
);
   import pdg_pkg::*;

   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_width
      $error("pulse_div_gen: CNT_W must lie in 1..32");
   end

   logic [CNT_W-1:0] cnt_q, cnt_d, reload_val, mux_out;
   logic             zero_det, sel_load, tick_d;
   pdg_phase_e       phase_q, phase_d;

   pdg_reload_calc #(.CNT_W(CNT_W)) u_reload (
      .div_i    (div_i),
      .reload_o (reload_val)
   );

   pdg_zero_det #(.CNT_W(CNT_W), .CHUNK(ZD_CHUNK)) u_zd (
      .cnt_i  (cnt_q),
      .zero_o (zero_det)
   );

   // Load after reset (prime) or on reaching zero; decrement otherwise.
   assign sel_load = zero_det | (phase_q == PH_PRIME);

   pdg_next_mux #(.CNT_W(CNT_W)) u_mux (
      .cnt_i      (cnt_q),
      .load_i     (reload_val),
      .sel_load_i (sel_load),
      .next_o     (mux_out)
   );

   always_comb begin
      cnt_d   = en_i ? mux_out : cnt_q;
      phase_d = en_i ? PH_RUN : phase_q;
      tick_d  = en_i & zero_det & (phase_q == PH_RUN);
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q   <= '0;
         phase_q <= PH_PRIME;
         tick_o  <= 1'b0;
      end else begin
         cnt_q   <= cnt_d;
         phase_q <= phase_d;
         tick_o  <= tick_d;
      end
   end

   // R1: a reset edge leaves the output quiet
   p_reset_quiet_r1: assert property (@(posedge clk_i)
      $past(rst_i) |-> !tick_o);

   // R2: a pulse only follows an enabled edge
   p_tick_needs_en_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      tick_o |-> $past(en_i));

   // R3: a non-zero running count steps down by one with no pulse
   p_decrement_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i && !zero_det && phase_q == PH_RUN)
      |=> (cnt_q == $past(cnt_q) - CNT_W'(1)) && !tick_o);

   // R8 and R4: the pulse edge also reloads from the divisor present at that edge
   p_reload_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i && zero_det && phase_q == PH_RUN)
      |=> tick_o && (cnt_q == $past(reload_val)));

   // R7: a disabled cycle freezes the count
   p_freeze_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |=> $stable(cnt_q) && !tick_o);
endmodule

// File: tb/pulse_div_gen_tb_top.sv
`timescale 1ns/1ps
module pulse_div_gen_tb_top;
   localparam int W = 8;

   logic         clk_i = 1'b0;
   logic         rst_i = 1'b1;
   logic         en_i  = 1'b0;
   logic [W-1:0] div_i = '0;
   logic         tick_o;

   int n_checks = 0;
   int n_errors = 0;

   always #10 clk_i = ~clk_i;   // 50 MHz

   pulse_div_gen #(.CNT_W(W)) dut_i (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .en_i   (en_i),
      .div_i  (div_i),
      .tick_o (tick_o)
   );

   // Table: divisor, enabled edges after reset, expected pulse count
   // expected = floor((M-1)/Neff), Neff = max(N,1)
   localparam int NV = 7;
   localparam int TBL_N  [NV] = '{1, 2, 3, 5, 0, 7, 255};
   localparam int TBL_M  [NV] = '{10, 10, 10, 21, 6, 15, 600};
   localparam int TBL_EXP[NV] = '{9, 4, 3, 4, 5, 2, 2};

   task automatic step();
      @(posedge clk_i);
      #2;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_i = 1'b1;
      en_i  = 1'b0;
      step();
      step();
      chk("R1 reset output low", int'(tick_o), 0);
      rst_i = 1'b0;
   endtask

   initial begin
      int pulses;
      int gap;
      int last;
      #1;
      // table-driven period checks (R3, R5, R6, R8)
      for (int v = 0; v < NV; v++) begin
         do_reset();
         div_i  = W'(TBL_N[v]);
         en_i   = 1'b1;
         pulses = 0;
         gap    = 0;
         last   = -1;
         for (int c = 1; c <= TBL_M[v]; c++) begin
            step();
            if (tick_o) begin
               pulses++;
               if (last >= 0) begin
                  gap = c - last;
                  // R8: no dead cycle between periods
                  chk($sformatf("R8 spacing N=%0d", TBL_N[v]), gap,
                      (TBL_N[v] == 0) ? 1 : TBL_N[v]);
               end
               last = c;
            end
         end
         chk($sformatf("R3/R5/R6 pulse count N=%0d", TBL_N[v]), pulses, TBL_EXP[v]);
      end

      // R1 and R3: first load gives no pulse, first pulse at edge N+1
      do_reset();
      div_i = 8'd3;
      en_i  = 1'b1;
      step(); chk("R1 load edge no pulse", int'(tick_o), 0);
      step(); chk("R3 edge2", int'(tick_o), 0);
      step(); chk("R3 edge3", int'(tick_o), 0);
      step(); chk("R3 edge4 pulse", int'(tick_o), 1);
      step(); chk("R2 single cycle width", int'(tick_o), 0);

      // R4: mid-period divisor change only hits the next period
      do_reset();
      div_i = 8'd4;
      en_i  = 1'b1;
      repeat (5) step();
      chk("R4 first pulse", int'(tick_o), 1);
      step();
      div_i = 8'd2;
      step(); chk("R4 old period edge7", int'(tick_o), 0);
      step(); chk("R4 old period edge8", int'(tick_o), 0);
      step(); chk("R4 old period ends edge9", int'(tick_o), 1);
      step(); chk("R4 new period edge10", int'(tick_o), 0);
      step(); chk("R4 new period edge11", int'(tick_o), 1);

      // R7: freeze while the count sits at zero, pulse held not lost
      do_reset();
      div_i = 8'd2;
      en_i  = 1'b1;
      step();
      step();
      en_i = 1'b0;
      pulses = 0;
      for (int c = 0; c < 4; c++) begin
         step();
         pulses += int'(tick_o);
      end
      chk("R7 no pulse while frozen", pulses, 0);
      en_i = 1'b1;
      step(); chk("R7 held pulse on resume", int'(tick_o), 1);
      step(); chk("R7 next period edge", int'(tick_o), 0);
      step(); chk("R7 next period pulse", int'(tick_o), 1);

      // R2 and R5: divisor 1 with gapped enable
      do_reset();
      div_i = 8'd1;
      en_i  = 1'b1;
      step();
      step(); chk("R5 enabled pulse", int'(tick_o), 1);
      en_i = 1'b0;
      step(); chk("R2 no pulse when disabled", int'(tick_o), 0);
      en_i = 1'b1;
      step(); chk("R5 pulse after gap", int'(tick_o), 1);
      step(); chk("R5 back-to-back pulse", int'(tick_o), 1);

      // R1: reset during a pulse stream
      rst_i = 1'b1;
      step(); chk("R1 reset mid-run", int'(tick_o), 0);
      rst_i = 1'b0;
      step(); chk("R1 post-reset load no pulse", int'(tick_o), 0);

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk_i);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule